// File: doc/BRIEF.md
# Texture Tile Swizzle Writer

The block turns a linear stream of texture data into pixel writes on a texture sheet. The sheet is 2048 cells wide, and each cell holds 16 bits. The source stream is made of 8x8-pixel tiles. The pixels inside each tile are stored in an interleaved order, and the block undoes that order while it places the tile on the sheet.

A job starts with a one-cycle `start_i` pulse. The pulse carries a destination origin, a width and a height in pixels, a pixel size (8 or 16 bits) and a little-endian flag. The block then takes 32-bit source words on a valid/ready handshake, one tile at a time, into a small tile buffer. It empties each tile as 64 single-pixel writes on a stallable write port. Every write carries a sheet cell address, 16 data bits and a 2-bit byte enable.

8-bit pixels are not widened. Two neighbouring 8-bit pixels share one cell, so an 8-bit tile covers only four cells across. A one-cycle done pulse marks the end of a job. A size that is zero or not a multiple of 8 raises an error flag, and the job then writes nothing.

Top module: `tile_swizzle_writer`

## Requirements
- R1: After reset, `wr_valid_o`, `done_o`, `err_o` and `src_ready_o` are low. An accepted start with a valid size takes exactly w*h*B/4 source words, where B is 2 for 16-bit pixels and 1 for 8-bit pixels. It makes exactly w*h writes. One cycle of `done_o` follows, after the last write has been accepted.
- R2: A start whose width or height is zero, or is not a multiple of 8, sets `err_o` high from the next cycle. After such a start there is no `src_ready_o`, no write and no `done_o`. The next accepted valid start clears `err_o`.
- R3: Byte k of a tile is the tile's source word k/4, bits [8*(k%4)+7 : 8*(k%4)]. The write for in-tile pixel (xi, yi) takes source pixel index {y2,y1,x2,x1,y0,x0}, MSB first. Here x and y are xi and yi after the endian correction of R4 or R5.
- R4: 16-bit pixel s is made of tile bytes 2s and 2s+1.
  - Little-endian mode flips x bit 0, and `wr_data_o` = {byte 2s+1, byte 2s}.
  - Big-endian mode applies no flip, and `wr_data_o` = {byte 2s, byte 2s+1}.
- R5: 8-bit pixel s is tile byte s. Little-endian mode flips both x bit 0 and y bit 0. Big-endian mode applies no flip.
- R6: For 16-bit pixels, `wr_addr_o` = Y*2048 + X, with X = tile origin x + xi and Y = tile origin y + yi. `wr_be_o` is 2'b11.
- R7: For 8-bit pixels, the cell is at X = tile origin x + xi/2 and Y = tile origin y + yi. `wr_be_o` is 2'b01 for even xi and 2'b10 for odd xi. `wr_data_o` carries the pixel byte in both halves.
- R8: Tiles are taken in row-major order. Tile (tx, ty) has its origin at (x0 + tx*8, y0 + ty*8) for 16-bit pixels and at (x0 + tx*4, y0 + ty*8) for 8-bit pixels. Within a tile, writes come in yi-major, then xi, order.
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, address, data and byte enable hold still, and no write is lost or repeated.
- R10: A start pulse during a running job is ignored. The size, origin and mode inputs are sampled only at an accepted start.
- R11: `src_ready_o` stays low from the acceptance of a tile's last word until all 64 writes of that tile are either accepted or held in the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; the configuration inputs are sampled with it |
| org_x_i | input | 11 | Destination origin x, in cells |
| org_y_i | input | 11 | Destination origin y, in rows |
| width_i | input | 12 | Texture width in pixels |
| height_i | input | 12 | Texture height in pixels |
| pix16_i | input | 1 | 1 = 16-bit pixels, 0 = 8-bit pixels |
| little_i | input | 1 | 1 = little-endian source layout |
| src_valid_i | input | 1 | Source word valid |
| src_ready_o | output | 1 | Source word accepted when high with valid |
| src_data_i | input | 32 | Source word |
| wr_valid_o | output | 1 | Sheet write valid |
| wr_ready_i | input | 1 | Sheet write accepted when high with valid |
| wr_addr_o | output | 22 | Sheet cell address, Y*2048 + X |
| wr_data_o | output | 16 | Write data |
| wr_be_o | output | 2 | Byte enable, bit 0 = data[7:0] |
| done_o | output | 1 | One-cycle end-of-job pulse |
| err_o | output | 1 | Last start had an illegal size |

## Verification
The assertions assume three things about the inputs:
- Reset is applied before any start.
- Each job stays inside the sheet, so the tile walker never wraps onto an earlier origin.
- `wr_ready_i` may change in any cycle.

The stimulus keeps every origin plus size inside the 2048x2048 sheet. It changes the configuration inputs only together with a start pulse, except in the one scenario that checks that a start during a job is ignored. Source gaps and write-port stalls come from a pseudo-random pattern, so the stall-hold and backpressure properties are exercised with many different stall lengths.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  localparam int TSW_TILE_DIM = 8;
  localparam int TSW_TILE_PIX = TSW_TILE_DIM * TSW_TILE_DIM;
  localparam int TSW_WORD_W   = 32;
  localparam int TSW_BUF_WORDS = TSW_TILE_PIX * 2 / (TSW_WORD_W / 8);
  localparam int TSW_BUF_AW   = $clog2(TSW_BUF_WORDS);

  typedef enum logic [1:0] {
    S_IDLE,
    S_FILL,
    S_DRAIN,
    S_FINISH
  } tsw_state_e;

endpackage

// File: rtl/tsw_tile_buf.sv
module tsw_tile_buf #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single write port and registered read port, suitable for block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // fill and drain phases never overlap in the buffer
  p_port_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    we |-> !re);

endmodule

// File: rtl/tsw_swizzle.sv
module tsw_swizzle #(
  parameter int AW = 5
) (
  input  logic          pix16,
  input  logic          little,
  input  logic [2:0]    xi,
  input  logic [2:0]    yi,
  output logic [AW-1:0] word_addr,
  output logic [1:0]    lane
);

  logic [2:0] xc;
  logic [2:0] yc;
  logic [5:0] sidx;

  always_comb begin
    // endian correction: 16-bit flips the pixel within a word,
    // 8-bit flips both the column and row pair
    xc = {xi[2:1], xi[0] ^ little};
    yc = {yi[2:1], yi[0] ^ (little & ~pix16)};
    // interleave of row and column bits inside the tile
    sidx = {yc[2], yc[1], xc[2], xc[1], yc[0], xc[0]};
    if (pix16) begin
      word_addr = AW'(sidx[5:1]);
      lane      = {sidx[0], 1'b0};
    end else begin
      word_addr = AW'(sidx[5:2]);
      lane      = sidx[1:0];
    end
  end

endmodule

// File: rtl/tsw_walker.sv
module tsw_walker #(
  parameter int XW   = 11,
  parameter int YW   = 11,
  parameter int TC_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init,
  input  logic [XW-1:0]   x0,
  input  logic [YW-1:0]   y0,
  input  logic [TC_W-1:0] tiles_x,
  input  logic [TC_W-1:0] tiles_y,
  input  logic            pix16,
  input  logic            step,
  output logic [XW-1:0]   org_x,
  output logic [YW-1:0]   org_y,
  output logic            last_tile
);

  logic [TC_W-1:0] tx, ty, ntx, nty;
  logic [XW-1:0]   row_x;
  logic [XW-1:0]   step_x;
  logic            row_end;

  assign row_end   = (tx == ntx - TC_W'(1));
  assign last_tile = row_end && (ty == nty - TC_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx     <= '0;
      ty     <= '0;
      ntx    <= '0;
      nty    <= '0;
      row_x  <= '0;
      step_x <= '0;
      org_x  <= '0;
      org_y  <= '0;
    end else if (init) begin
      tx     <= '0;
      ty     <= '0;
      ntx    <= tiles_x;
      nty    <= tiles_y;
      row_x  <= x0;
      org_x  <= x0;
      org_y  <= y0;
      // an 8-bit tile packs two pixels per cell, so it spans half the cells
      step_x <= pix16 ? XW'(8) : XW'(4);
    end else if (step) begin
      if (row_end) begin
        tx    <= '0;
        ty    <= ty + TC_W'(1);
        org_x <= row_x;
        org_y <= org_y + YW'(8);
      end else begin
        tx    <= tx + TC_W'(1);
        org_x <= org_x + step_x;
      end
    end
  end

  p_tile_moves_r8: assert property (@(posedge clk) disable iff (rst)
    (step && !init && !last_tile) |=> (org_x != $past(org_x)) || (org_y != $past(org_y)));

endmodule

// File: rtl/tile_swizzle_writer.sv
module tile_swizzle_writer
  import tsw_pkg::*;
#(
  parameter int SHEET_W = 2048,
  parameter int SHEET_H = 2048,
  parameter int DIM_W   = 12,
  localparam int XW     = $clog2(SHEET_W),
  localparam int YW     = $clog2(SHEET_H),
  localparam int ADDR_W = XW + YW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [XW-1:0]     org_x_i,
  input  logic [YW-1:0]     org_y_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic              pix16_i,
  input  logic              little_i,
  input  logic              src_valid_i,
  output logic              src_ready_o,
  input  logic [31:0]       src_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [15:0]       wr_data_o,
  output logic [1:0]        wr_be_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int TC_W = DIM_W - 3;
  localparam int AW   = TSW_BUF_AW;
  localparam logic [AW-1:0] FILL_LAST16 = AW'(TSW_BUF_WORDS - 1);
  localparam logic [AW-1:0] FILL_LAST8  = AW'(TSW_BUF_WORDS / 2 - 1);

  tsw_state_e state;
  logic           cfg_is16, cfg_le;
  logic [AW-1:0]  fill_cnt;
  logic [6:0]     iss_cnt;
  logic           iss_more, adv, rd_en;
  logic           b_valid;
  logic [2:0]     b_xi, b_yi;
  logic [1:0]     b_lane;
  logic           bad_size, accept, tile_end;
  logic           wr_valid_q, done_q, err_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [15:0]    wr_data_q;
  logic [1:0]     wr_be_q;

  logic [AW-1:0]  rd_addr;
  logic [1:0]     rd_lane;
  logic [31:0]    rd_word;
  logic [XW-1:0]  wk_x;
  logic [YW-1:0]  wk_y;
  logic           wk_last;

  logic [XW-1:0]  pix_x;
  logic [YW-1:0]  pix_y;
  logic [7:0]     pix_byte;
  logic [15:0]    pix_half;
  logic [15:0]    pix_data;
  logic [1:0]     pix_be;

  assign bad_size = (width_i[2:0] != 3'd0) || (height_i[2:0] != 3'd0) ||
                    (width_i == '0) || (height_i == '0);
  assign accept   = (state == S_IDLE) && start_i && !bad_size;
  assign iss_more = !iss_cnt[6];
  assign adv      = !wr_valid_q || wr_ready_i;
  assign rd_en    = (state == S_DRAIN) && iss_more && adv;
  assign tile_end = (state == S_DRAIN) && !iss_more && !b_valid;
  assign src_ready_o = (state == S_FILL);

  tsw_tile_buf #(.AW(AW), .DW(TSW_WORD_W)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .we    (src_ready_o && src_valid_i),
    .waddr (fill_cnt),
    .wdata (src_data_i),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  tsw_swizzle #(.AW(AW)) u_swz (
    .pix16     (cfg_is16),
    .little    (cfg_le),
    .xi        (iss_cnt[2:0]),
    .yi        (iss_cnt[5:3]),
    .word_addr (rd_addr),
    .lane      (rd_lane)
  );

  tsw_walker #(.XW(XW), .YW(YW), .TC_W(TC_W)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .init      (accept),
    .x0        (org_x_i),
    .y0        (org_y_i),
    .tiles_x   (width_i[DIM_W-1:3]),
    .tiles_y   (height_i[DIM_W-1:3]),
    .pix16     (pix16_i),
    .step      (tile_end && !wk_last),
    .org_x     (wk_x),
    .org_y     (wk_y),
    .last_tile (wk_last)
  );

  // pixel formation from the buffer word read in the previous stage
  always_comb begin
    pix_byte = rd_word[{b_lane, 3'b000} +: 8];
    pix_half = b_lane[1] ? rd_word[31:16] : rd_word[15:0];
    if (cfg_is16) begin
      pix_x    = wk_x + XW'(b_xi);
      pix_data = cfg_le ? pix_half : {pix_half[7:0], pix_half[15:8]};
      pix_be   = 2'b11;
    end else begin
      pix_x    = wk_x + XW'(b_xi[2:1]);
      pix_data = {pix_byte, pix_byte};
      pix_be   = b_xi[0] ? 2'b10 : 2'b01;
    end
    pix_y = wk_y + YW'(b_yi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cfg_is16   <= 1'b0;
      cfg_le     <= 1'b0;
      fill_cnt   <= '0;
      iss_cnt    <= '0;
      b_valid    <= 1'b0;
      b_xi       <= '0;
      b_yi       <= '0;
      b_lane     <= '0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      wr_be_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      // read stage and output register advance together
      if (adv) begin
        b_valid    <= rd_en;
        b_xi       <= iss_cnt[2:0];
        b_yi       <= iss_cnt[5:3];
        b_lane     <= rd_lane;
        wr_valid_q <= b_valid;
        if (b_valid) begin
          wr_addr_q <= {pix_y, pix_x};
          wr_data_q <= pix_data;
          wr_be_q   <= pix_be;
        end
      end
      if (rd_en) iss_cnt <= iss_cnt + 7'd1;
      unique case (state)
        S_IDLE: begin
          if (start_i) begin
            err_q <= bad_size;
            if (!bad_size) begin
              cfg_is16 <= pix16_i;
              cfg_le   <= little_i;
              fill_cnt <= '0;
              state    <= S_FILL;
            end
          end
        end
        S_FILL: begin
          if (src_valid_i) begin
            if (fill_cnt == (cfg_is16 ? FILL_LAST16 : FILL_LAST8)) begin
              fill_cnt <= '0;
              iss_cnt  <= '0;
              state    <= S_DRAIN;
            end else begin
              fill_cnt <= fill_cnt + AW'(1);
            end
          end
        end
        S_DRAIN: begin
          if (tile_end) state <= wk_last ? S_FINISH : S_FILL;
        end
        S_FINISH: begin
          if (!wr_valid_q) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign wr_be_o    = wr_be_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i) |=> wr_valid_o && $stable(wr_addr_o) &&
                                    $stable(wr_data_o) && $stable(wr_be_o));

  p_full_be_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && cfg_is16) |-> (wr_be_o == 2'b11));

  p_byte_be_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !cfg_is16) |-> ($countones(wr_be_o) == 1));

  p_err_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!src_ready_o && !wr_valid_o && !done_o));

  p_done_drained_r1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !wr_valid_o);

  p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> $stable(err_o));

endmodule

// File: tb/tile_swizzle_writer_tb.sv
`timescale 1ns/1ps
module tile_swizzle_writer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [10:0] org_x_i = '0, org_y_i = '0;
  logic [11:0] width_i = '0, height_i = '0;
  logic        pix16_i = 1'b0, little_i = 1'b0;
  logic        src_valid_i = 1'b0;
  logic        src_ready_o;
  logic [31:0] src_data_i = '0;
  logic        wr_valid_o;
  logic        wr_ready_i = 1'b1;
  logic [21:0] wr_addr_o;
  logic [15:0] wr_data_o;
  logic [1:0]  wr_be_o;
  logic        done_o, err_o;

  always #4 clk = ~clk;

  tile_swizzle_writer u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .org_x_i(org_x_i), .org_y_i(org_y_i),
    .width_i(width_i), .height_i(height_i), .pix16_i(pix16_i), .little_i(little_i),
    .src_valid_i(src_valid_i), .src_ready_o(src_ready_o), .src_data_i(src_data_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_be_o(wr_be_o), .done_o(done_o), .err_o(err_o)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] words [2048];
  int s_n = 0, s_idx = 0, wpt = 32;
  bit s_fire = 1'b0, src_on = 1'b0, gap_mode = 1'b0, stall_mode = 1'b0;
  int wr_acc = 0, done_cnt = 0, r11_bad = 0, src_seen = 0, wr_seen = 0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_tag = "";
  logic [21:0] exp_addr [$];
  logic [15:0] exp_data [$];
  logic [1:0]  exp_be [$];

  task automatic chk(input bit ok, input string msg, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, expv);
    end
  endtask

  function automatic logic [7:0] srcb(input int k);
    return 8'((k * 29 + 11 + (k / 128) * 5) % 256);
  endfunction

  // source driver, write monitor and port observers, all away from the active edge
  always @(negedge clk) begin
    if (s_fire) s_idx++;
    if (src_on && s_idx < s_n && !(gap_mode && lfsr[0])) begin
      src_valid_i = 1'b1;
      src_data_i  = words[s_idx];
    end else begin
      src_valid_i = 1'b0;
    end
    s_fire = src_valid_i && src_ready_o;
    if (src_ready_o) src_seen++;
    if (wr_valid_o) wr_seen++;
    // R11: a tile is fully written or held before the next tile is taken
    if (src_ready_o && src_on && (wr_acc + int'(wr_valid_o)) < 64 * (s_idx / wpt)) r11_bad++;
    wr_ready_i = stall_mode ? lfsr[1] : 1'b1;
    if (wr_valid_o && wr_ready_i) begin
      n_checks++;
      if (exp_addr.size() == 0) begin
        n_fail++;
        $display("FAIL %s unexpected write: actual addr %h expected none", cur_tag, wr_addr_o);
      end else begin
        if (wr_addr_o !== exp_addr[0] || wr_data_o !== exp_data[0] || wr_be_o !== exp_be[0]) begin
          n_fail++;
          $display("FAIL %s write %0d: actual addr %h data %h be %b expected addr %h data %h be %b",
                   cur_tag, wr_acc, wr_addr_o, wr_data_o, wr_be_o,
                   exp_addr[0], exp_data[0], exp_be[0]);
        end
        void'(exp_addr.pop_front());
        void'(exp_data.pop_front());
        void'(exp_be.pop_front());
      end
      wr_acc++;
    end
    if (done_o) done_cnt++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  task automatic pulse_start(input int x0, y0, w, h, input bit p16, le);
    @(negedge clk);
    org_x_i = 11'(x0); org_y_i = 11'(y0);
    width_i = 12'(w);  height_i = 12'(h);
    pix16_i = p16;     little_i = le;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // one texture job; expected writes computed from R3..R8
  task automatic run_job(input int x0, y0, w, h, input bit p16, le, st, gp, poke,
                         input string tag);
    int bpp, ntx, nty, stepx, t, base, xs, ys, s, xx, yy, wait_n;
    logic [7:0] b0, b1;
    bpp = p16 ? 2 : 1;
    ntx = w / 8; nty = h / 8; stepx = p16 ? 8 : 4;
    exp_addr.delete(); exp_data.delete(); exp_be.delete();
    for (int ty = 0; ty < nty; ty++)
      for (int tx = 0; tx < ntx; tx++)
        for (int yi = 0; yi < 8; yi++)
          for (int xi = 0; xi < 8; xi++) begin
            t = ty * ntx + tx;
            base = t * 64 * bpp;
            xs = xi ^ int'(le);
            ys = p16 ? yi : (yi ^ int'(le));
            s = (((ys >> 2) & 1) << 5) | (((ys >> 1) & 1) << 4) | (((xs >> 2) & 1) << 3) |
                (((xs >> 1) & 1) << 2) | ((ys & 1) << 1) | (xs & 1);
            yy = y0 + ty * 8 + yi;
            if (p16) begin
              b0 = srcb(base + 2 * s);
              b1 = srcb(base + 2 * s + 1);
              xx = x0 + tx * stepx + xi;
              exp_data.push_back(le ? {b1, b0} : {b0, b1});
              exp_be.push_back(2'b11);
            end else begin
              b0 = srcb(base + s);
              xx = x0 + tx * stepx + xi / 2;
              exp_data.push_back({b0, b0});
              exp_be.push_back((xi % 2) != 0 ? 2'b10 : 2'b01);
            end
            exp_addr.push_back(22'(yy * 2048 + xx));
          end
    s_n = w * h * bpp / 4;
    for (int j = 0; j < s_n; j++)
      words[j] = {srcb(4 * j + 3), srcb(4 * j + 2), srcb(4 * j + 1), srcb(4 * j)};
    wpt = 16 * bpp;
    s_idx = 0; s_fire = 1'b0; wr_acc = 0; done_cnt = 0; r11_bad = 0;
    stall_mode = st; gap_mode = gp; cur_tag = tag;
    pulse_start(x0, y0, w, h, p16, le);
    src_on = 1'b1;
    if (poke) begin
      repeat (30) @(negedge clk);
      // R10: a start during the job, with other inputs, must be ignored
      pulse_start(x0 + 300, y0 + 300, 12, 8, !p16, !le);
    end
    wait_n = 0;
    while (done_cnt == 0 && wait_n < 40000) begin
      @(negedge clk);
      wait_n++;
    end
    repeat (4) @(negedge clk);
    src_on = 1'b0; stall_mode = 1'b0; gap_mode = 1'b0;
    chk(done_cnt == 1, {tag, " R1 done pulses"}, done_cnt, 1);
    chk(s_idx == s_n, {tag, " R1 words taken"}, s_idx, s_n);
    chk(wr_acc == w * h, {tag, " R1 writes made"}, wr_acc, w * h);
    chk(exp_addr.size() == 0, {tag, " R8 writes missing"}, exp_addr.size(), 0);
    chk(r11_bad == 0, {tag, " R11 source taken early"}, r11_bad, 0);
    chk(err_o == 1'b0, {tag, " R10 err after job"}, int'(err_o), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_valid_o == 1'b0, "R1 reset wr_valid", int'(wr_valid_o), 0);
    chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    chk(err_o == 1'b0, "R1 reset err", int'(err_o), 0);
    chk(src_ready_o == 1'b0, "R1 reset src_ready", int'(src_ready_o), 0);
  endtask

  task automatic t_bad_size(input int w, h, input string tag);
    done_cnt = 0; src_seen = 0; wr_seen = 0;
    pulse_start(40, 40, w, h, 1'b1, 1'b1);
    chk(err_o == 1'b1, {tag, " R2 err set"}, int'(err_o), 1);
    repeat (20) @(negedge clk);
    chk(src_seen == 0, {tag, " R2 no source ready"}, src_seen, 0);
    chk(wr_seen == 0, {tag, " R2 no writes"}, wr_seen, 0);
    chk(done_cnt == 0, {tag, " R2 no done"}, done_cnt, 0);
  endtask

  initial begin
    t_reset();
    run_job(16, 24, 8, 8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 R4 R6 16-bit little");
    run_job(100, 40, 16, 8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 R8 16-bit big");
    run_job(200, 8, 16, 16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 R7 R8 8-bit little");
    run_job(36, 500, 8, 16, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 R7 8-bit big");
    run_job(1000, 1200, 16, 16, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R9 R11 16-bit stalls");
    run_job(512, 2000, 24, 8, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9 R11 8-bit stalls");
    t_bad_size(12, 8, "width 12");
    t_bad_size(8, 0, "height 0");
    run_job(64, 64, 8, 8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 err cleared");
    run_job(300, 96, 16, 16, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R10 busy start");
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule